// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries a processor core into an interrupt, software-interrupt or undefined-instruction exception. A request arrives on a valid/ready handshake together with its kind, the program counter, the status word and a flag that says whether the core is running compact 16-bit instructions. On acceptance the block captures all of these values. It then runs a fixed two-cycle sequence. The first cycle tells the banked register file which mode to switch to. The second cycle writes the link register, the saved status, the new status and the program counter, clears the halted flag for an interrupt, and asks the fetch stage to refill.

Back-pressure: `req_ready` is high only while the sequencer is idle. A request counts as taken on a clock edge where both `req_valid` and `req_ready` are high. While a sequence runs, the requester must hold its request and its operands steady, and the block takes nothing. An interrupt request that arrives while the status I bit is set is taken on the handshake and then dropped, so it never stalls the requester.

Kind encoding: 0 is undefined instruction, 1 is software interrupt, 2 is interrupt, and 3 is reserved. Status word fields: mode is bits [4:0], the compact-state flag is bit 5, and the interrupt-disable flag I is bit 7.

Top module: `exc_entry_seq`

## Requirements
- R1: `req_ready` is high exactly when `busy` is low. After an accepted request that is not discarded, `busy` is high for exactly two cycles and then falls. No request is accepted while `busy` is high.
- R2: An accepted request of kind 2 (interrupt) whose status bit 7 is 1 is discarded: no write strobe, mode change or busy follows. Kinds 0 and 1 are taken whatever the value of bit 7.
- R3: In the first busy cycle only `mode_chg_valid` is high. `mode_chg_target` is 5'h12 for an interrupt, 5'h13 for a software interrupt and 5'h1B for an undefined instruction.
- R4: For kinds 0 and 1, `lr_data` equals the captured PC minus 4 when `cur_compact` was 0, and minus 2 when it was 1.
- R5: For kind 2, `lr_data` equals the captured PC minus the instruction width plus 4.
- R6: `spsr_data` equals the status word captured at acceptance. Changes on `cur_psr` after acceptance have no effect on it.
- R7: `pc_data` is 0x04 for an undefined instruction, 0x08 for a software interrupt and 0x18 for an interrupt.
- R8: `psr_data` is the captured status with bits [4:0] replaced by the target mode, bit 5 cleared and bit 7 set.
- R9: In the second busy cycle `lr_we`, `spsr_we`, `psr_we`, `pc_we` and `refill` all pulse for one cycle. `halt_clr` pulses in that cycle only for kind 2.
- R10: An accepted request of kind 3 is discarded, with no strobe and no busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Exception request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_kind | input | 2 | 0 undefined, 1 software interrupt, 2 interrupt, 3 reserved |
| cur_pc | input | 32 | Current program counter |
| cur_psr | input | 32 | Current status word |
| cur_compact | input | 1 | 1 when the core executes 16-bit instructions |
| busy | output | 1 | Sequence in progress |
| mode_chg_valid | output | 1 | Mode switch strobe to the banked register file |
| mode_chg_target | output | 5 | Target mode code |
| lr_we | output | 1 | Link register write strobe |
| lr_data | output | 32 | Return address |
| spsr_we | output | 1 | Saved-status write strobe |
| spsr_data | output | 32 | Status word saved for the target mode |
| psr_we | output | 1 | Current-status write strobe |
| psr_data | output | 32 | New status word |
| pc_we | output | 1 | Program counter write strobe |
| pc_data | output | 32 | Vector address |
| halt_clr | output | 1 | Clears the halted flag |
| refill | output | 1 | Pipeline refill request |

## Verification
Two things can fall in the same cycle: a fresh request and the second, write cycle of the sequence already running. The bench starts a software-interrupt entry and keeps `req_valid` high with an undefined-instruction request through both busy cycles. It checks that `req_ready` stays low, that the write cycle still carries the first entry's vector and link, and that the second request is taken only on the edge after `busy` falls, with its own mode code.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [1:0] {
    K_UND = 2'd0,
    K_SWI = 2'd1,
    K_IRQ = 2'd2,
    K_RSV = 2'd3
  } exc_kind_e;

  localparam int MODE_W    = 5;
  localparam int PSR_I_BIT = 7;
  localparam int PSR_T_BIT = 5;

  localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;

  localparam int VEC_UND = 32'h04;
  localparam int VEC_SWI = 32'h08;
  localparam int VEC_IRQ = 32'h18;

  localparam int WIDE_BYTES    = 4;
  localparam int COMPACT_BYTES = 2;
endpackage

// File: rtl/exc_target_calc.sv
module exc_target_calc
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  exc_kind_e          kind,
  input  logic [XLEN-1:0]    pc,
  input  logic               compact,
  output logic [MODE_W-1:0]  mode,
  output logic [XLEN-1:0]    vector,
  output logic [XLEN-1:0]    link
);
  localparam logic [XLEN-1:0] W_WIDE    = XLEN'(WIDE_BYTES);
  localparam logic [XLEN-1:0] W_COMPACT = XLEN'(COMPACT_BYTES);

  logic [XLEN-1:0] width;
  logic [XLEN-1:0] bias;

  always_comb begin
    width = compact ? W_COMPACT : W_WIDE;
    bias  = '0;
    unique case (kind)
      K_IRQ: begin
        mode   = MODE_IRQ;
        vector = XLEN'(VEC_IRQ);
        bias   = W_WIDE;
      end
      K_SWI: begin
        mode   = MODE_SVC;
        vector = XLEN'(VEC_SWI);
      end
      default: begin
        mode   = MODE_UND;
        vector = XLEN'(VEC_UND);
      end
    endcase
    link = pc - width + bias;
  end
endmodule

// File: rtl/exc_ctrl_fsm.sv
module exc_ctrl_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic idle,
  output logic in_mode,
  output logic in_write
);
  typedef enum logic [1:0] {S_IDLE, S_MODE, S_WRITE} st_e;
  st_e st, st_n;

  always_comb begin
    st_n = st;
    unique case (st)
      S_IDLE:  if (go) st_n = S_MODE;
      S_MODE:  st_n = S_WRITE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= S_IDLE;
    else        st <= st_n;

  assign idle     = (st == S_IDLE);
  assign in_mode  = (st == S_MODE);
  assign in_write = (st == S_WRITE);

  a_r1_two_step: assert property (@(posedge clk) disable iff (!rst_n)
    in_mode |=> in_write);
  a_r1_return_idle: assert property (@(posedge clk) disable iff (!rst_n)
    in_write |=> idle);
  a_r1_go_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && go) |=> in_mode);
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   cur_psr,
  input  logic              cur_compact,
  output logic              busy,
  output logic              mode_chg_valid,
  output logic [MODE_W-1:0] mode_chg_target,
  output logic              lr_we,
  output logic [XLEN-1:0]   lr_data,
  output logic              spsr_we,
  output logic [XLEN-1:0]   spsr_data,
  output logic              psr_we,
  output logic [XLEN-1:0]   psr_data,
  output logic              pc_we,
  output logic [XLEN-1:0]   pc_data,
  output logic              halt_clr,
  output logic              refill
);
  exc_kind_e       kind_in, kind_q;
  logic [XLEN-1:0] pc_q, psr_q;
  logic            compact_q;
  logic            accept, masked, go;
  logic            idle, in_mode, in_write;
  logic [MODE_W-1:0] tgt_mode;
  logic [XLEN-1:0] vec, link;

  assign kind_in = exc_kind_e'(req_kind);
  assign accept  = req_valid && req_ready;
  assign masked  = (kind_in == K_RSV) ||
                   ((kind_in == K_IRQ) && cur_psr[PSR_I_BIT]);
  assign go      = accept && !masked;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      kind_q    <= K_UND;
      pc_q      <= '0;
      psr_q     <= '0;
      compact_q <= 1'b0;
    end else if (go) begin
      kind_q    <= kind_in;
      pc_q      <= cur_pc;
      psr_q     <= cur_psr;
      compact_q <= cur_compact;
    end

  exc_ctrl_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .go(go),
    .idle(idle), .in_mode(in_mode), .in_write(in_write)
  );

  exc_target_calc #(.XLEN(XLEN)) u_calc (
    .kind(kind_q), .pc(pc_q), .compact(compact_q),
    .mode(tgt_mode), .vector(vec), .link(link)
  );

  always_comb begin
    psr_data = psr_q;
    psr_data[MODE_W-1:0] = tgt_mode;
    psr_data[PSR_T_BIT]  = 1'b0;
    psr_data[PSR_I_BIT]  = 1'b1;
  end

  assign req_ready       = idle;
  assign busy            = !idle;
  assign mode_chg_valid  = in_mode;
  assign mode_chg_target = tgt_mode;
  assign lr_we           = in_write;
  assign lr_data         = link;
  assign spsr_we         = in_write;
  assign spsr_data       = psr_q;
  assign psr_we          = in_write;
  assign pc_we           = in_write;
  assign pc_data         = vec;
  assign refill          = in_write;
  assign halt_clr        = in_write && (kind_q == K_IRQ);

  a_r2_masked_irq_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind_in == K_IRQ && cur_psr[PSR_I_BIT]) |=> !busy);
  a_r10_reserved_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind_in == K_RSV) |=> !busy);
  a_r3_mode_before_write: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg_valid |=> (lr_we && !mode_chg_valid));
  a_r8_status_forced: assert property (@(posedge clk) disable iff (!rst_n)
    psr_we |-> (psr_data[PSR_I_BIT] && !psr_data[PSR_T_BIT]));
  a_r9_halt_only_irq: assert property (@(posedge clk) disable iff (!rst_n)
    halt_clr |-> (pc_data == XLEN'(VEC_IRQ) && refill));
  a_r6_saved_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(spsr_data));
  a_r1_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_kind = 2'd0;
  logic [31:0] cur_pc = '0, cur_psr = '0;
  logic cur_compact = 1'b0;
  logic busy, mode_chg_valid, lr_we, spsr_we, psr_we, pc_we, halt_clr, refill;
  logic [4:0] mode_chg_target;
  logic [31:0] lr_data, spsr_data, psr_data, pc_data;

  int n_run = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  exc_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .cur_pc(cur_pc), .cur_psr(cur_psr), .cur_compact(cur_compact),
    .busy(busy), .mode_chg_valid(mode_chg_valid), .mode_chg_target(mode_chg_target),
    .lr_we(lr_we), .lr_data(lr_data), .spsr_we(spsr_we), .spsr_data(spsr_data),
    .psr_we(psr_we), .psr_data(psr_data), .pc_we(pc_we), .pc_data(pc_data),
    .halt_clr(halt_clr), .refill(refill)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  localparam int NV = 6;
  localparam logic [1:0]  T_KIND [NV] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd2};
  localparam logic        T_CMP  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [31:0] T_PC   [NV] = '{32'h1000, 32'h2002, 32'h8000, 32'h0100, 32'h3000, 32'h0400};
  localparam logic [31:0] T_PSR  [NV] = '{32'h1F, 32'h3F, 32'h10, 32'hF0000030, 32'h1F, 32'h2000003F};

  function automatic logic [4:0] exp_mode(input logic [1:0] k);
    return (k == 2'd2) ? 5'h12 : (k == 2'd1) ? 5'h13 : 5'h1B;
  endfunction
  function automatic logic [31:0] exp_vec(input logic [1:0] k);
    return (k == 2'd2) ? 32'h18 : (k == 2'd1) ? 32'h08 : 32'h04;
  endfunction
  function automatic logic [31:0] exp_lr(input logic [1:0] k, input logic c, input logic [31:0] pc);
    logic [31:0] w;
    w = c ? 32'd2 : 32'd4;
    return (k == 2'd2) ? pc - w + 32'd4 : pc - w;
  endfunction

  // drives one request, walks both busy cycles and the return to idle
  task automatic entry(input logic [1:0] k, input logic c, input logic [31:0] pc, input logic [31:0] psr);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; cur_compact = c; cur_pc = pc; cur_psr = psr;
    #1 chk("R1 ready before take", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0; cur_psr = 32'hDEADBEEF; cur_pc = 32'h5555AAAA; cur_compact = ~c;
    #1;
    chk("R1 busy first", {31'd0, busy}, 32'd1);
    chk("R3 mode strobe", {31'd0, mode_chg_valid}, 32'd1);
    chk("R3 mode code", {27'd0, mode_chg_target}, {27'd0, exp_mode(k)});
    chk("R3 no write yet", {31'd0, lr_we | pc_we | psr_we | spsr_we}, 32'd0);
    @(negedge clk); #1;
    chk("R9 strobes", {27'd0, lr_we, spsr_we, psr_we, pc_we, refill}, 32'h1F);
    chk("R9 halt_clr", {31'd0, halt_clr}, {31'd0, k == 2'd2});
    chk(k == 2'd2 ? "R5 irq link" : "R4 link", lr_data, exp_lr(k, c, pc));
    chk("R6 saved status", spsr_data, psr);
    chk("R7 vector", pc_data, exp_vec(k));
    chk("R8 new status", psr_data, (psr & ~32'h3F) | 32'h80 | {27'd0, exp_mode(k)});
    @(negedge clk); #1;
    chk("R1 idle after two", {30'd0, busy, req_ready}, 32'd1);
  endtask

  task automatic dropped(input logic [1:0] k, input logic [31:0] psr, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; cur_psr = psr; cur_pc = 32'h700;
    @(negedge clk);
    req_valid = 1'b0; #1;
    chk(req, {29'd0, busy, mode_chg_valid, req_ready}, 32'd1);
    @(negedge clk); #1;
    chk(req, {26'd0, lr_we, pc_we, psr_we, spsr_we, halt_clr, refill}, 32'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #1;
    chk("R1 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R9 reset strobes", {28'd0, busy, lr_we, pc_we, mode_chg_valid}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) entry(T_KIND[i], T_CMP[i], T_PC[i], T_PSR[i]);

    // R2: masked interrupt is dropped; R10: reserved kind is dropped
    dropped(2'd2, 32'h9F, "R2 masked irq");
    dropped(2'd3, 32'h1F, "R10 reserved kind");
    // R2: software interrupt and undefined still taken with I set
    entry(2'd1, 1'b0, 32'h44, 32'h9F);
    entry(2'd0, 1'b1, 32'h46, 32'h9F);
    // R4 wrap-around at address zero
    entry(2'd1, 1'b1, 32'h0, 32'h10);

    // back-pressure: second request held while the first sequence runs
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd1; cur_compact = 1'b0; cur_pc = 32'h900; cur_psr = 32'h10;
    @(negedge clk);
    req_kind = 2'd0; cur_pc = 32'hA00; #1;
    chk("R1 held not ready", {31'd0, req_ready}, 32'd0);
    @(negedge clk); #1;
    chk("R1 held not ready w", {31'd0, req_ready}, 32'd0);
    chk("R7 first vector kept", pc_data, 32'h08);
    chk("R4 first link kept", lr_data, 32'h8FC);
    @(negedge clk); #1;
    chk("R1 ready after", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0; #1;
    chk("R3 second mode", {27'd0, mode_chg_target}, 32'h1B);
    @(negedge clk); #1;
    chk("R4 second link", lr_data, 32'h9FC);
    @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule